// File: doc/BRIEF.md
# Infrared Carrier Timer with Pulse-Interval Demodulation

This block is an 8-bit down-counter for infrared links. It has two jobs, picked by a mode bit. In transmit mode it alternates between two programmed hold counts to build a square waveform. Each level lasts one hold count plus one tick, so the duty cycle and the frequency can be set separately. In demodulation mode it watches a deglitched infrared input. The first selected edge starts the counter from the all-ones value. Each later selected edge stores the current count, raises a capture interrupt if that interrupt is allowed, and starts the count again from all ones.

Software controls the block through a small register port. The port holds a run bit, a one-shot bit, a sticky done flag that is cleared by writing 1 to it, a tick divider, a done-interrupt enable, the starting output level, the mode bit, the edge choice and the capture-interrupt enable. The counter advances only on prescaler ticks. The input filter and the edge detector run on every clock.

Register map. Offset 0 is control: bit 7 run, bit 6 one-shot, bit 5 done flag, bits 4:3 divider select, bit 2 done-interrupt enable, bit 1 starting level, bit 0 mode (0 transmit, 1 demodulate). Offset 1 is edge configuration: bits 1:0 edge choice, bit 2 capture-interrupt enable. Offset 2 is hold A, offset 3 is hold B and offset 4 is the captured count, which is read-only. Every other offset reads as zero.

Top module: `ir_carrier_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0, and `wave_out`, `irq_timeout` and `irq_capture` are 0.
- R2: A control write that sets run while run is 0 in transmit mode drives `wave_out` to the starting level on that same clock edge. At that edge the counter loads hold A if the level is 1 and hold B if the level is 0.
- R3: When the counter reaches terminal count in transmit mode without one-shot, `wave_out` inverts and the counter loads the hold that matches the new level (A for 1, B for 0). Each level therefore lasts (hold+1) ticks.
- R4: With one-shot set in transmit mode, terminal count clears run and sets the done flag, and `wave_out` keeps its level.
- R5: A tick occurs once every 2^sel clocks, where sel is control bits 4:3. With sel set to 0 the counter advances on every clock.
- R6: Reaching terminal count sets the done flag (control bit 5). Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R7: `irq_timeout` is high exactly while the done flag and the done-interrupt enable (control bit 2) are both 1.
- R8: The edge choice field selects which edges count: 00 none, 01 rising, 10 falling, 11 both.
- R9: In demodulation mode the first selected edge starts the count from FFh. Each later selected edge stores the count into the capture register, pulses `irq_capture` for one cycle if capture-interrupt enable is set, and restarts the count from FFh. With sel 0 and edges D clocks apart, the stored value is 256-D.
- R10: In demodulation mode, if no selected edge arrives for 256 ticks after the last one, the done flag is set and run clears. An edge that lands on that same tick takes priority: it stores 00h and no timeout occurs.
- R11: A level change on `ir_in` that lasts fewer than FILT_LEN clocks produces no edge.
- R12: Writes to the mode bit are ignored while run is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ir_in | input | 1 | Raw infrared input |
| wave_out | output | 1 | Transmit waveform |
| irq_timeout | output | 1 | Done interrupt (level) |
| irq_capture | output | 1 | Capture interrupt (one-cycle pulse) |

## Verification
In demodulation mode, the capture caused by a selected edge and the wrap-around timeout can fall on the same clock. That happens when two edges arrive exactly 256 ticks apart. The bench sets this up by placing two rising input edges exactly 256 clocks apart with the divider at 1. It then expects a stored 00h, a clear done flag and run still set. A second run with the edges 257 clocks apart must instead leave the old capture value unchanged, set the done flag and clear run.

// File: rtl/ir_timer_pkg.sv
package ir_timer_pkg;

    localparam int REG_W  = 8;
    localparam int CNT_W  = 8;
    localparam int CSEL_W = 2;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_EDGE = 3'd1;
    localparam logic [2:0] A_HLDA = 3'd2;
    localparam logic [2:0] A_HLDB = 3'd3;
    localparam logic [2:0] A_CAPT = 3'd4;

    typedef enum logic { MODE_TX = 1'b0, MODE_DEMOD = 1'b1 } irt_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic              run;
        logic              single;
        logic              flag;
        logic [CSEL_W-1:0] sel;
        logic              tmask;
        logic              init;
        irt_mode_e         mode;
    } ctrl_t;

    function automatic logic edge_hit(edge_sel_e es, logic rise, logic fall);
        logic [1:0] b;
        b = es;
        return (b[0] & rise) | (b[1] & fall);
    endfunction

endpackage

// File: rtl/irt_edge_sense.sv
module irt_edge_sense #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic rise,
    output logic fall
);
    logic [1:0] sync_q;
    logic       filt_q;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], raw_in};
    end

    generate
        if (FILT_LEN > 1) begin : g_filter
            localparam int CW = $clog2(FILT_LEN);
            logic [CW-1:0] run_cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    filt_q  <= 1'b0;
                    run_cnt <= '0;
                end else if (sync_q[1] != filt_q) begin
                    if (run_cnt == CW'(FILT_LEN - 1)) begin
                        filt_q  <= sync_q[1];
                        run_cnt <= '0;
                    end else begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end else begin
                    run_cnt <= '0;
                end
            end
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (rst) filt_q <= 1'b0;
                else     filt_q <= sync_q[1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= filt_q;
    end

    assign rise = filt_q & ~prev_q;
    assign fall = ~filt_q & prev_q;
endmodule

// File: rtl/irt_tick_gen.sv
module irt_tick_gen
    import ir_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CSEL_W-1:0] sel,
    output logic              tick
);
    localparam int PW = (1 << CSEL_W) - 1;

    logic [PW-1:0] presc_q;
    logic [PW-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) presc_q <= '0;
        else     presc_q <= presc_q + 1'b1;
    end

    always_comb begin
        for (int i = 0; i < PW; i++) mask[i] = (i < int'(sel));
    end

    assign tick = &(presc_q | ~mask);
endmodule

// File: rtl/irt_count_core.sv
module irt_count_core
    import ir_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  irt_mode_e        start_mode,
    input  logic             start_init,
    input  logic             en,
    input  irt_mode_e        mode,
    input  logic             single,
    input  logic [CNT_W-1:0] hold_a,
    input  logic [CNT_W-1:0] hold_b,
    input  logic             tick,
    input  logic             edge_ev,
    output logic             lvl_out,
    output logic [CNT_W-1:0] cap_val,
    output logic             timeout_evt,
    output logic             stop_evt,
    output logic             capture_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             active;
    logic             at_zero;
    logic             tx_term;
    logic             dm_term;

    assign active  = en && !start;
    assign at_zero = (cnt_q == '0);
    assign tx_term = active && (mode == MODE_TX) && tick && at_zero;
    assign dm_term = active && (mode == MODE_DEMOD) && busy_q && !edge_ev && tick && at_zero;

    assign timeout_evt = tx_term || dm_term;
    assign stop_evt    = (tx_term && single) || dm_term;
    assign capture_evt = active && (mode == MODE_DEMOD) && busy_q && edge_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            lvl_out <= 1'b0;
            cap_val <= '0;
        end else if (start) begin
            busy_q <= 1'b0;
            if (start_mode == MODE_TX) begin
                lvl_out <= start_init;
                cnt_q   <= start_init ? hold_a : hold_b;
            end else begin
                cnt_q <= '1;
            end
        end else if (en) begin
            if (mode == MODE_TX) begin
                if (tick) begin
                    if (at_zero) begin
                        if (!single) begin
                            lvl_out <= ~lvl_out;
                            cnt_q   <= lvl_out ? hold_b : hold_a;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end else begin
                if (edge_ev) begin
                    if (busy_q) cap_val <= cnt_q;
                    cnt_q  <= '1;
                    busy_q <= 1'b1;
                end else if (busy_q && tick) begin
                    if (at_zero) busy_q <= 1'b0;
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ir_carrier_timer.sv
module ir_carrier_timer
    import ir_timer_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             ir_in,
    output logic             wave_out,
    output logic             irq_timeout,
    output logic             irq_capture
);
    ctrl_t            ctrl_q;
    ctrl_t            wctrl;
    edge_sel_e        esel_q;
    logic             cap_ie_q;
    logic [CNT_W-1:0] hold_a_q;
    logic [CNT_W-1:0] hold_b_q;
    logic [CNT_W-1:0] cap_val;
    logic             cap_irq_q;

    logic wr_ctrl;
    logic start;
    logic tick;
    logic rise;
    logic fall;
    logic edge_ev;
    logic timeout_evt;
    logic stop_evt;
    logic capture_evt;

    assign wctrl   = ctrl_t'(wdata);
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign start   = wr_ctrl && wctrl.run && !ctrl_q.run;
    assign edge_ev = edge_hit(esel_q, rise, fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            esel_q    <= EDGE_NONE;
            cap_ie_q  <= 1'b0;
            hold_a_q  <= '0;
            hold_b_q  <= '0;
            cap_irq_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run    <= wctrl.run;
                ctrl_q.single <= wctrl.single;
                ctrl_q.sel    <= wctrl.sel;
                ctrl_q.tmask  <= wctrl.tmask;
                ctrl_q.init   <= wctrl.init;
                if (!ctrl_q.run) ctrl_q.mode <= wctrl.mode;
            end else if (stop_evt) begin
                ctrl_q.run <= 1'b0;
            end

            if (timeout_evt)                 ctrl_q.flag <= 1'b1;
            else if (wr_ctrl && wctrl.flag)  ctrl_q.flag <= 1'b0;

            if (wr_en && addr == A_EDGE) begin
                esel_q   <= edge_sel_e'(wdata[1:0]);
                cap_ie_q <= wdata[2];
            end
            if (wr_en && addr == A_HLDA) hold_a_q <= wdata;
            if (wr_en && addr == A_HLDB) hold_b_q <= wdata;

            cap_irq_q <= capture_evt && cap_ie_q;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_EDGE:  rdata = {{(REG_W-3){1'b0}}, cap_ie_q, esel_q};
            A_HLDA:  rdata = hold_a_q;
            A_HLDB:  rdata = hold_b_q;
            A_CAPT:  rdata = cap_val;
            default: rdata = '0;
        endcase
    end

    irt_edge_sense #(.FILT_LEN(FILT_LEN)) u_edge (
        .clk(clk), .rst(rst), .raw_in(ir_in), .rise(rise), .fall(fall)
    );

    irt_tick_gen u_tick (
        .clk(clk), .rst(rst), .sel(ctrl_q.sel), .tick(tick)
    );

    irt_count_core u_core (
        .clk(clk), .rst(rst),
        .start(start), .start_mode(wctrl.mode), .start_init(wctrl.init),
        .en(ctrl_q.run), .mode(ctrl_q.mode), .single(ctrl_q.single),
        .hold_a(hold_a_q), .hold_b(hold_b_q),
        .tick(tick), .edge_ev(edge_ev),
        .lvl_out(wave_out), .cap_val(cap_val),
        .timeout_evt(timeout_evt), .stop_evt(stop_evt), .capture_evt(capture_evt)
    );

    assign irq_timeout = ctrl_q.flag && ctrl_q.tmask;
    assign irq_capture = cap_irq_q;
endmodule

// File: rtl/irt_checker.sv
module irt_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic run_q,
    input logic mode_q,
    input logic flag_q,
    input logic wave_out,
    input logic irq_capture
);
    // R12: the mode bit holds while run stays set
    assert_mode_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> $stable(mode_q));

    // R2: the waveform moves only on a start write or while running
    assert_wave_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(wave_out) |-> ($past(run_q) || $past(wr_en)));

    // R9: capture interrupts occur only in demodulation mode
    assert_capture_demod_R9: assert property (@(posedge clk) disable iff (rst)
        irq_capture |-> mode_q);

    // R6: the done flag can only rise from a running counter
    assert_flag_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(run_q));

    // R10: a demodulation timeout stops the counter
    assert_demod_stop_R10: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag_q) && mode_q && !$past(wr_en)) |-> !run_q);
endmodule

bind ir_carrier_timer irt_checker u_irt_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .run_q(ctrl_q.run), .mode_q(ctrl_q.mode), .flag_q(ctrl_q.flag),
    .wave_out(wave_out), .irq_capture(irq_capture)
);

// File: tb/ir_carrier_timer_tb.sv
module ir_carrier_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ir_in = 1'b0;
    logic       wave_out;
    logic       irq_timeout;
    logic       irq_capture;

    int n_checks = 0;
    int n_fails  = 0;
    int cap_seen = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ir_carrier_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ir_in(ir_in), .wave_out(wave_out),
        .irq_timeout(irq_timeout), .irq_capture(irq_capture)
    );

    always @(negedge clk) if (!rst && irq_capture) cap_seen++;

    typedef struct packed {
        logic [1:0]  sel;
        logic        init;
        logic [7:0]  hold_a;
        logic [7:0]  hold_b;
        logic [15:0] len_first;
        logic [15:0] len_second;
    } tx_vec_t;

    // expected lengths: first measured level is ~init, then init; (hold+1)<<sel
    localparam tx_vec_t TX_VECS [5] = '{
        '{2'd0, 1'b1, 8'd5, 8'd3, 16'd4,  16'd6},
        '{2'd0, 1'b0, 8'd2, 8'd7, 16'd3,  16'd8},
        '{2'd1, 1'b1, 8'd0, 8'd0, 16'd2,  16'd2},
        '{2'd2, 1'b0, 8'd4, 8'd1, 16'd20, 16'd8},
        '{2'd3, 1'b1, 8'd1, 8'd2, 16'd24, 16'd16}
    };

    function automatic logic [7:0] ctrl(logic run, logic single, logic flag,
                                        logic [1:0] sel, logic tmask, logic init, logic mode);
        return {run, single, flag, sel, tmask, init, mode};
    endfunction

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_toggle(output int n);
        logic p;
        p = wave_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (wave_out == p && n < 5000);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    // demod pulse: spacing D between the two selected edges, base level first
    task automatic demod_pair(logic base, logic both, int d);
        ir_in = ~base;
        if (both) begin
            wait_cycles(d);
            ir_in = base;
        end else begin
            wait_cycles(20);
            ir_in = base;
            wait_cycles(d - 20);
            ir_in = ~base;
        end
        wait_cycles(10);
    endtask

    task automatic demod_start(logic base, logic [1:0] esel);
        ir_in = base;
        wait_cycles(10);
        reg_write(3'd1, {5'd0, 1'b1, esel});
        reg_write(3'd0, ctrl(1, 0, 1, 2'd0, 0, 0, 1));
    endtask

    task automatic demod_stop();
        reg_write(3'd0, ctrl(0, 0, 1, 2'd0, 0, 0, 1));
    endtask

    initial begin
        logic [7:0] rv;
        int len1;
        int len2;
        int base_cap;

        wait_cycles(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_read(3'd0, rv); check("R1 ctrl", rv, 0);
        reg_read(3'd4, rv); check("R1 capture", rv, 0);
        check("R1 outputs", {wave_out, irq_timeout, irq_capture}, 0);

        // R2 R3 R5 vector table: transmit waveform
        for (int i = 0; i < 5; i++) begin
            reg_write(3'd0, ctrl(0, 0, 1, 2'd0, 0, 0, 0));
            reg_write(3'd2, TX_VECS[i].hold_a);
            reg_write(3'd3, TX_VECS[i].hold_b);
            reg_write(3'd0, ctrl(1, 0, 1, TX_VECS[i].sel, 0, TX_VECS[i].init, 0));
            check("R2 start level", wave_out, TX_VECS[i].init);
            wait_toggle(len1);
            wait_toggle(len1);
            wait_toggle(len2);
            check("R3 R5 first level length", len1, TX_VECS[i].len_first);
            check("R3 R5 second level length", len2, TX_VECS[i].len_second);
        end

        // R12 mode write ignored while running
        reg_write(3'd0, ctrl(1, 0, 0, 2'd0, 0, 0, 1));
        reg_read(3'd0, rv); check("R12 mode kept", rv[0], 0);
        wait_toggle(len1);
        check("R12 still transmitting", len1 < 100, 1);

        // R4 single pass, R6 flag write behaviour, R7 interrupt gating
        reg_write(3'd0, ctrl(0, 0, 1, 2'd0, 0, 0, 0));
        reg_write(3'd2, 8'd3);
        reg_write(3'd0, ctrl(1, 1, 1, 2'd0, 0, 1, 0));
        check("R2 single start level", wave_out, 1);
        wait_cycles(10);
        reg_read(3'd0, rv); check("R4 run cleared flag set", rv, 8'h62);
        check("R4 level held", wave_out, 1);
        check("R7 masked", irq_timeout, 0);
        reg_write(3'd0, ctrl(0, 1, 0, 2'd0, 1, 1, 0));
        reg_read(3'd0, rv); check("R6 write 0 keeps flag", rv, 8'h66);
        check("R7 unmasked", irq_timeout, 1);
        reg_write(3'd0, ctrl(0, 1, 1, 2'd0, 1, 1, 0));
        reg_read(3'd0, rv); check("R6 write 1 clears flag", rv, 8'h46);
        check("R7 cleared", irq_timeout, 0);

        // R9 rising edges 100 apart
        base_cap = cap_seen;
        demod_start(1'b0, 2'b01);
        demod_pair(1'b0, 1'b0, 100);
        reg_read(3'd4, rv); check("R9 rising capture", rv, 8'h9C);
        reg_read(3'd0, rv); check("R9 still running", rv, 8'h81);
        check("R9 capture irq", cap_seen - base_cap, 1);
        demod_stop();

        // R8 falling edges 60 apart
        demod_start(1'b1, 2'b10);
        demod_pair(1'b1, 1'b0, 60);
        reg_read(3'd4, rv); check("R8 falling capture", rv, 8'hC4);
        demod_stop();

        // R8 both edges, rise then fall 40 apart
        demod_start(1'b0, 2'b11);
        demod_pair(1'b0, 1'b1, 40);
        reg_read(3'd4, rv); check("R8 both-edge capture", rv, 8'hD8);
        demod_stop();

        // R8 none selected: no capture, no timeout
        base_cap = cap_seen;
        demod_start(1'b0, 2'b00);
        demod_pair(1'b0, 1'b0, 60);
        wait_cycles(300);
        reg_read(3'd0, rv); check("R8 none keeps running", rv, 8'h81);
        check("R8 none no capture", cap_seen - base_cap, 0);
        demod_stop();

        // R11 glitch rejection
        base_cap = cap_seen;
        demod_start(1'b0, 2'b01);
        ir_in = 1'b1;
        wait_cycles(50);
        ir_in = 1'b0;
        wait_cycles(2);
        ir_in = 1'b1;
        wait_cycles(30);
        ir_in = 1'b0;
        wait_cycles(38);
        ir_in = 1'b1;
        wait_cycles(10);
        reg_read(3'd4, rv); check("R11 glitch ignored", rv, 8'h88);
        check("R11 one capture", cap_seen - base_cap, 1);
        demod_stop();

        // R10 edges 257 apart: timeout wins, capture unchanged
        base_cap = cap_seen;
        demod_start(1'b0, 2'b01);
        demod_pair(1'b0, 1'b0, 257);
        reg_read(3'd0, rv); check("R10 timeout stops", rv, 8'h21);
        reg_read(3'd4, rv); check("R10 capture unchanged", rv, 8'h88);
        check("R10 no capture irq", cap_seen - base_cap, 0);
        demod_stop();

        // R10 edges exactly 256 apart: edge wins, stores 00
        base_cap = cap_seen;
        demod_start(1'b0, 2'b01);
        demod_pair(1'b0, 1'b0, 256);
        reg_read(3'd0, rv); check("R10 edge beats timeout", rv, 8'h81);
        reg_read(3'd4, rv); check("R10 capture zero", rv, 8'h00);
        check("R10 capture irq", cap_seen - base_cap, 1);
        demod_stop();

        finish_run();
    end
endmodule